// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This unit adds or subtracts two 32-bit tagged words. The integer value sits in the upper 30 bits of each word, and a 2-bit type tag sits in the lowest two bits. A word whose tag is zero is a plain small integer. Any other tag means the operand must go to a slow software path. The unit produces the sum or difference together with negative, zero, overflow and carry flags.

The unit has two flavours. The quiet flavour always writes its result. It folds a tag problem into the overflow flag, and it also sets that flag on ordinary signed overflow. The trapping flavour raises a trap request on either condition. When it traps, it suppresses the write and leaves the result and flags untouched. The tag test looks only at the operand tag bits, so it runs beside the adder and never waits on the sum.

The surrounding pipeline presents one operation per cycle with a valid strobe. It takes the registered outcome one cycle later.

Top module: `tagged_alu`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `out_valid`, `out_wr_en`, `out_trap`, `out_result` and `out_flags` are all zero.
- R2: `in_op` bit 0 selects subtract (1) or add (0), and bit 1 selects the trapping flavour (1) or the quiet flavour (0). An operation accepted with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high in that cycle. Its result is `in_a + in_b` or `in_a - in_b`, modulo 2^32.
- R3: A tag fault exists when bits [1:0] of `in_a` or bits [1:0] of `in_b` are non-zero.
- R4: A quiet operation never raises `out_trap`. It always drives `out_wr_en` high and updates the result. It sets V (`out_flags[1]`) when a tag fault or signed 32-bit overflow occurs, and clears V otherwise.
- R5: A trapping operation with a tag fault or signed overflow drives `out_trap` high and `out_wr_en` low. It leaves `out_result` and `out_flags` at their previous values.
- R6: A trapping operation without tag fault or overflow drives `out_trap` low and `out_wr_en` high. It updates result and flags, with V clear.
- R7: On every write, N (`out_flags[3]`) equals result bit 31, and Z (`out_flags[2]`) is high exactly when the result is zero.
- R8: On every write, C (`out_flags[0]`) is the carry out of bit 31 for add. For subtract, C is high exactly when `in_a >= in_b` as unsigned numbers.
- R9: In a cycle following one with `in_valid` low, `out_valid`, `out_wr_en` and `out_trap` are low, and `out_result` and `out_flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Bit 0 subtract, bit 1 trapping flavour |
| in_a | input | 32 | First tagged operand |
| in_b | input | 32 | Second tagged operand |
| out_valid | output | 1 | Registered outcome of last cycle's operation |
| out_result | output | 32 | Registered sum or difference |
| out_flags | output | 4 | {N, Z, V, C} |
| out_wr_en | output | 1 | Result was written this cycle |
| out_trap | output | 1 | Trap request for last cycle's operation |

## Verification
All four opcodes are swept across every pair taken from a set of operands. The set mixes clean tags, each non-zero tag, both signed extremes, values near the sign boundary and zero. Pairs with a clean tag and no overflow separate correct arithmetic and carry from flag errors. Pairs that cross the sign boundary separate signed overflow from unsigned carry. Pairs with a dirty tag but a harmless sum show that the fault comes from the tag bits and not from the adder. Idle cycles between operations show that trapped and idle cycles leave the held result and flags alone.

// File: rtl/tagged_alu_pkg.sv
package tagged_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD      = 2'b00,
        OP_SUB      = 2'b01,
        OP_ADD_TRAP = 2'b10,
        OP_SUB_TRAP = 2'b11
    } tag_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/tag_check.sv
module tag_check #(
    parameter int WORD_W = 32,
    parameter int TAG_W  = 2,
    parameter int N_OPS  = 2
) (
    input  logic [N_OPS-1:0][WORD_W-1:0] operands,
    output logic                         fault
);
    logic [N_OPS-1:0] op_dirty;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_op
            assign op_dirty[gi] = |operands[gi][TAG_W-1:0];
        end
    endgenerate

    assign fault = |op_dirty;
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              sub,
    output logic [WORD_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] b_eff;
    logic [WORD_W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WORD_W{1'b0}}, sub};
        sum   = wide[WORD_W-1:0];
        carry = wide[WORD_W];
        ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/tagged_alu.sv
module tagged_alu
    import tagged_alu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic [3:0]        out_flags,
    output logic              out_wr_en,
    output logic              out_trap
);
    localparam int MSB = WORD_W - 1;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic              trap;
        logic [WORD_W-1:0] result;
        alu_flags_t        flags;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [WORD_W-1:0] sum;
    logic              carry;
    logic              arith_ovf;
    logic              tag_fault;
    tag_op_e           op;

    assign op = tag_op_e'(in_op);

    tag_check #(.WORD_W(WORD_W), .TAG_W(TAG_W), .N_OPS(2)) i_tag_check (
        .operands ({in_a, in_b}),
        .fault    (tag_fault)
    );

    addsub_core #(.WORD_W(WORD_W)) i_addsub_core (
        .a     (in_a),
        .b     (in_b),
        .sub   (op == OP_SUB || op == OP_SUB_TRAP),
        .sum   (sum),
        .carry (carry),
        .ovf   (arith_ovf)
    );

    always_comb begin
        logic problem;
        logic trapping;
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr    = 1'b0;
        st_d.trap  = 1'b0;
        problem    = tag_fault | arith_ovf;
        trapping   = (op == OP_ADD_TRAP) || (op == OP_SUB_TRAP);
        if (in_valid) begin
            if (trapping && problem) begin
                st_d.trap = 1'b1;
            end else begin
                st_d.wr      = 1'b1;
                st_d.result  = sum;
                st_d.flags.n = sum[MSB];
                st_d.flags.z = (sum == '0);
                st_d.flags.v = problem;
                st_d.flags.c = carry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_wr_en  = st_q.wr;
    assign out_trap   = st_q.trap;
    assign out_result = st_q.result;
    assign out_flags  = st_q.flags;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !out_wr_en && !out_trap
                              && $stable(out_result) && $stable(out_flags)));

    // R5
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (!out_wr_en && $stable(out_result) && $stable(out_flags)));

    // R4
    quiet_never_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !$past(in_op[1])) |-> (!out_trap && out_wr_en));

    // R6
    clean_trap_op_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(in_op[1]) && out_wr_en) |-> !out_flags[1]);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_flags[2] == (out_result == '0)));
endmodule

// File: tb/test_tagged_alu.sv
module test_tagged_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NVAL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_flags;
    logic        out_wr_en;
    logic        out_trap;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_res   = '0;
    logic [3:0]  m_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_alu i_tagged_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_flags(out_flags), .out_wr_en(out_wr_en), .out_trap(out_trap)
    );

    function automatic logic [31:0] pick(int i);
        case (i)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0004;
            2:  return 32'h0000_0008;
            3:  return 32'h7FFF_FFFC;
            4:  return 32'h8000_0000;
            5:  return 32'hFFFF_FFFC;
            6:  return 32'h4000_0000;
            7:  return 32'hC000_0000;
            8:  return 32'h0000_0001;
            9:  return 32'h0000_0002;
            10: return 32'h7FFF_FFFF;
            default: return 32'h1234_5678;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        longint sa, sb, sr;
        logic [32:0] w;
        logic ovf, tagf, prob, trap_exp;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        sr = op[0] ? sa - sb : sa + sb;
        ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        tagf = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);      // R3
        prob = ovf || tagf;
        if (op[0]) w = {1'b0, a} + {1'b0, ~b} + 33'd1;
        else       w = {1'b0, a} + {1'b0, b};
        trap_exp = op[1] && prob;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (!trap_exp) begin
            m_res = w[31:0];
            m_flags = {w[31], (w[31:0] == 32'd0), prob,
                       op[0] ? (a >= b) : w[32]};
        end
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        check(op[1] ? "R5/R6 trap" : "R4 trap", {31'd0, out_trap}, {31'd0, trap_exp});
        check(op[1] ? "R5/R6 wr_en" : "R4 wr_en", {31'd0, out_wr_en}, {31'd0, !trap_exp});
        check("R2 result", out_result, m_res);
        check("R7/R8 flags (R4 V)", {28'd0, out_flags}, {28'd0, m_flags});
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        check("R9 valid", {31'd0, out_valid}, 32'd0);
        check("R9 wr_en", {31'd0, out_wr_en}, 32'd0);
        check("R9 trap", {31'd0, out_trap}, 32'd0);
        check("R9 result", out_result, m_res);
        check("R9 flags", {28'd0, out_flags}, {28'd0, m_flags});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 wr_en", {31'd0, out_wr_en}, 32'd0);
        check("R1 trap", {31'd0, out_trap}, 32'd0);
        check("R1 result", out_result, 32'd0);
        check("R1 flags", {28'd0, out_flags}, 32'd0);
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < NVAL; i++) begin
                for (int j = 0; j < NVAL; j++) begin
                    run_op(op[1:0], pick(i), pick(j));
                    if (((i + j) % 5) == 0) idle_cycle();
                end
            end
        end
        // R5: trap right after a write must keep that write's result
        run_op(2'b00, 32'h0000_0010, 32'h0000_0020);
        run_op(2'b10, 32'h7FFF_FFFC, 32'h0000_0004);
        idle_cycle();
        // R6: clean trapping subtract to zero
        run_op(2'b11, 32'h0000_0040, 32'h0000_0040);
        idle_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule